// File: doc/BRIEF.md
# Multicore External Interrupt Distributor

This block fans a set of level-sensitive external interrupt lines out to up to four processor cores. Every line passes through a global enable mask. A software-assert mask can force a line active whatever its pin level. A per-line routing word then picks which cores see it. Each core receives one output vector. Bits 0 to 2 of that vector carry a 3-bit inter-processor interrupt input for that core. Line i sits at bit i+2.

Software programs the block through a word-addressed register port. Each access carries the index of the core that makes it. Line 0 is reserved: it has no pin, so it can only become active through the assert mask. The external pins therefore map to lines 1 and up. All output vectors are registered.

Top module: `irq_distrib`

## Requirements
- R1: While reset is held, every core output and the read data are zero. After reset every implemented line is enabled, the assert mask is clear, and every routing word reads 1, so each line goes to core 0 only.
- R2: Core c's output is computed from ext = {ext_irq_i, 1'b0}, so pin j-1 drives line j. The output is ((((ext & enable) | assert) & route_c) << 2) | ipi_c. Here route_c has bit i set when line i's routing word has bit c set, and ipi_c is ipi_i[3c+2:3c].
- R3: Word offset i, for 0 <= i < NUM_EXT+1, is line i's routing word. Bit c of it routes the line to core c. A write keeps only bits NUM_CORES-1:0, and a read returns that stored value zero-extended.
- R4: A write to offset 0x184 ORs the written bits into the enable mask. A write to 0x180 clears the written bits from it.
- R5: A write to offset 0x18C ORs the written bits into the assert mask. A write to 0x188 clears the written bits from it.
- R6: A read of 0x180 or 0x184 returns the enable mask. A read of 0x188 or 0x18C returns the assert mask.
- R7: A read of offset 0x1A0 returns ((NUM_CORES-1) << 18) | bus_core_i. A write to 0x1A0 has no effect.
- R8: At every other offset a write changes no state and a read returns zero.
- R9: Core outputs change exactly one clock after a change of ext_irq_i, ipi_i or a mask, and hold otherwise. Read data appears one clock after a read request and holds until the next read.
- R10: Line 0 can only be made active through the assert mask. It appears at output bit 2, ORed with ipi bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | NUM_EXT | Level external interrupts, pin j-1 is line j |
| ipi_i | input | 3*NUM_CORES | Per-core 3-bit inter-processor interrupt vector |
| bus_en_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_core_i | input | CORE_W | Index of the requesting core |
| bus_rdata_o | output | 32 | Registered read data |
| core_irq_o | output | NUM_CORES*(NUM_EXT+3) | Per-core output vectors, core c at slice c |

## Verification
The hardest situation to reach is one where all three gates disagree on the same line. An example is a line that is enabled but routed away while its assert bit is set. Another is line 0, which can only be reached through the assert mask, colliding with ipi bit 2. Random stimulus alone rarely produces these. The stimulus therefore mixes random register writes, biased toward the set/clear and routing offsets, with random pin and ipi levels. Directed sequences then build these overlaps explicitly, and every cycle is compared against a bench-side model of all cores.

// File: rtl/irq_distrib_pkg.sv
package irq_distrib_pkg;

  localparam int OFS_EN_CLR  = 32'h180;
  localparam int OFS_EN_SET  = 32'h184;
  localparam int OFS_ASG_CLR = 32'h188;
  localparam int OFS_ASG_SET = 32'h18C;
  localparam int OFS_CFG_ID  = 32'h1A0;
  localparam int CFG_SHIFT   = 18;
  localparam int IPI_W       = 3;
  localparam int LINE_SHIFT  = 2;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_ROUTE,
    REG_EN_CLR,
    REG_EN_SET,
    REG_ASG_CLR,
    REG_ASG_SET,
    REG_CFG
  } reg_kind_e;

endpackage

// File: rtl/irq_distrib_decode.sv
module irq_distrib_decode
  import irq_distrib_pkg::*;
#(
  parameter int NL     = 16,
  parameter int ADDR_W = 9,
  localparam int IDX_W = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  always_comb begin
    kind_o = REG_NONE;
    if (int'(addr_i) < NL) begin
      kind_o = REG_ROUTE;
    end else begin
      case (int'(addr_i))
        OFS_EN_CLR:  kind_o = REG_EN_CLR;
        OFS_EN_SET:  kind_o = REG_EN_SET;
        OFS_ASG_CLR: kind_o = REG_ASG_CLR;
        OFS_ASG_SET: kind_o = REG_ASG_SET;
        OFS_CFG_ID:  kind_o = REG_CFG;
        default:     kind_o = REG_NONE;
      endcase
    end
  end

  assign idx_o = addr_i[IDX_W-1:0];

endmodule

// File: rtl/irq_distrib_regs.sv
module irq_distrib_regs
  import irq_distrib_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NL        = 16,
  localparam int IDX_W    = (NL > 1) ? $clog2(NL) : 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_i,
  input  logic                            rd_i,
  input  reg_kind_e                       kind_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [31:0]                     wdata_i,
  input  logic [CORE_W-1:0]               core_i,
  output logic [NL-1:0]                   en_mask_o,
  output logic [NL-1:0]                   asg_mask_o,
  output logic [NL-1:0][NUM_CORES-1:0]    route_o,
  output logic [31:0]                     rdata_o
);

  localparam logic [NUM_CORES-1:0] ROUTE_RST = NUM_CORES'(1);
  localparam logic [31:0] CFG_BASE = 32'((NUM_CORES - 1) << CFG_SHIFT);

  logic [NL-1:0]                en_q, en_d, asg_q, asg_d;
  logic                         en_ce, asg_ce;
  logic [NL-1:0][NUM_CORES-1:0] route_q;
  logic [NL-1:0]                route_ce;
  logic [NL-1:0]                wbits;
  logic [31:0]                  rd_val, rdata_q;
  logic                         unused_wdata;

  assign wbits        = wdata_i[NL-1:0];
  assign unused_wdata = ^wdata_i;

  // Enable mask next state
  always_comb begin
    en_d  = en_q;
    en_ce = 1'b0;
    if (wr_i && kind_i == REG_EN_SET) begin
      en_d  = en_q | wbits;
      en_ce = 1'b1;
    end else if (wr_i && kind_i == REG_EN_CLR) begin
      en_d  = en_q & ~wbits;
      en_ce = 1'b1;
    end
  end

  // Assert mask next state
  always_comb begin
    asg_d  = asg_q;
    asg_ce = 1'b0;
    if (wr_i && kind_i == REG_ASG_SET) begin
      asg_d  = asg_q | wbits;
      asg_ce = 1'b1;
    end else if (wr_i && kind_i == REG_ASG_CLR) begin
      asg_d  = asg_q & ~wbits;
      asg_ce = 1'b1;
    end
  end

  // Per-line routing write enables
  for (genvar i = 0; i < NL; i++) begin : g_route_ce
    assign route_ce[i] = wr_i && (kind_i == REG_ROUTE) && (int'(idx_i) == i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '1;
      asg_q <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (asg_ce) asg_q <= asg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) route_q[i] <= ROUTE_RST;
    end else begin
      for (int i = 0; i < NL; i++) begin
        if (route_ce[i]) route_q[i] <= wdata_i[NUM_CORES-1:0];
      end
    end
  end

  // Read mux
  always_comb begin
    case (kind_i)
      REG_ROUTE:               rd_val = 32'(route_q[idx_i]);
      REG_EN_CLR, REG_EN_SET:  rd_val = 32'(en_q);
      REG_ASG_CLR, REG_ASG_SET: rd_val = 32'(asg_q);
      REG_CFG:                 rd_val = CFG_BASE | 32'(core_i);
      default:                 rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rd_val;
    end
  end

  assign en_mask_o  = en_q;
  assign asg_mask_o = asg_q;
  assign route_o    = route_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/irq_distrib_core_out.sv
module irq_distrib_core_out
  import irq_distrib_pkg::*;
#(
  parameter int NL     = 16,
  localparam int OUT_W = NL + LINE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NL-1:0]    ext_state_i,
  input  logic [NL-1:0]    en_mask_i,
  input  logic [NL-1:0]    asg_mask_i,
  input  logic [NL-1:0]    route_i,
  input  logic [IPI_W-1:0] ipi_i,
  output logic [OUT_W-1:0] irq_o
);

  logic [NL-1:0]    line_act;
  logic [OUT_W-1:0] irq_d, irq_q;
  logic             irq_ce;

  always_comb begin
    line_act = ((ext_state_i & en_mask_i) | asg_mask_i) & route_i;
    irq_d    = {line_act, {LINE_SHIFT{1'b0}}} | OUT_W'(ipi_i);
    irq_ce   = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else if (irq_ce) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_distrib.sv
module irq_distrib
  import irq_distrib_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_EXT   = 15,
  parameter int ADDR_W    = 9,
  localparam int NL       = NUM_EXT + 1,
  localparam int OUT_W    = NL + LINE_SHIFT,
  localparam int IDX_W    = (NL > 1) ? $clog2(NL) : 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_EXT-1:0]           ext_irq_i,
  input  logic [NUM_CORES*IPI_W-1:0]   ipi_i,
  input  logic                         bus_en_i,
  input  logic                         bus_we_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [31:0]                  bus_wdata_i,
  input  logic [CORE_W-1:0]            bus_core_i,
  output logic [31:0]                  bus_rdata_o,
  output logic [NUM_CORES*OUT_W-1:0]   core_irq_o
);

  logic                         wr_act, rd_act;
  reg_kind_e                    kind;
  logic [IDX_W-1:0]             idx;
  logic [NL-1:0]                en_mask, asg_mask, ext_state;
  logic [NL-1:0][NUM_CORES-1:0] route;
  logic [NUM_CORES*NL-1:0]      route_col_flat;

  assign wr_act    = bus_en_i & bus_we_i;
  assign rd_act    = bus_en_i & ~bus_we_i;
  assign ext_state = {ext_irq_i, 1'b0};

  irq_distrib_decode #(.NL(NL), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  irq_distrib_regs #(.NUM_CORES(NUM_CORES), .NL(NL)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_act),
    .rd_i       (rd_act),
    .kind_i     (kind),
    .idx_i      (idx),
    .wdata_i    (bus_wdata_i),
    .core_i     (bus_core_i),
    .en_mask_o  (en_mask),
    .asg_mask_o (asg_mask),
    .route_o    (route),
    .rdata_o    (bus_rdata_o)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar i = 0; i < NL; i++) begin : g_col
      assign route_col_flat[c*NL + i] = route[i][c];
    end

    irq_distrib_core_out #(.NL(NL)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_state_i (ext_state),
      .en_mask_i   (en_mask),
      .asg_mask_i  (asg_mask),
      .route_i     (route_col_flat[c*NL +: NL]),
      .ipi_i       (ipi_i[c*IPI_W +: IPI_W]),
      .irq_o       (core_irq_o[c*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/irq_distrib_chk.sv
module irq_distrib_chk
  import irq_distrib_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_EXT   = 15,
  parameter int ADDR_W    = 9,
  localparam int NL       = NUM_EXT + 1,
  localparam int OUT_W    = NL + LINE_SHIFT,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_EXT-1:0]         ext_irq_i,
  input logic [NUM_CORES*IPI_W-1:0] ipi_i,
  input logic                       bus_en_i,
  input logic                       bus_we_i,
  input logic [ADDR_W-1:0]          bus_addr_i,
  input logic [31:0]                bus_wdata_i,
  input logic [CORE_W-1:0]          bus_core_i,
  input logic [31:0]                bus_rdata_o,
  input logic [NUM_CORES*OUT_W-1:0] core_irq_o,
  input logic [NL-1:0]              en_mask,
  input logic [NL-1:0]              asg_mask,
  input logic [NUM_CORES*NL-1:0]    route_col_flat
);

  logic [1:0] cyc;
  logic       cyc_ok, wr, rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc <= '0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  assign cyc_ok = (cyc == 2'd3);
  assign wr     = bus_en_i & bus_we_i;
  assign rd     = bus_en_i & ~bus_we_i;

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(bus_addr_i) == OFS_EN_SET) |=> ((en_mask & $past(bus_wdata_i[NL-1:0])) == $past(bus_wdata_i[NL-1:0]))); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(bus_addr_i) == OFS_EN_CLR) |=> ((en_mask & $past(bus_wdata_i[NL-1:0])) == '0)); // R4
  AST_ASG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(bus_addr_i) == OFS_ASG_SET) |=> ((asg_mask & $past(bus_wdata_i[NL-1:0])) == $past(bus_wdata_i[NL-1:0]))); // R5
  AST_ASG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(bus_addr_i) == OFS_ASG_CLR) |=> ((asg_mask & $past(bus_wdata_i[NL-1:0])) == '0)); // R5
  AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && int'(bus_addr_i) == OFS_CFG_ID) |=> (bus_rdata_o == (32'((NUM_CORES-1) << CFG_SHIFT) | 32'($past(bus_core_i))))); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && int'(bus_addr_i) >= NL && int'(bus_addr_i) < OFS_EN_CLR) |=> (bus_rdata_o == '0)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && !$past(rd)) |-> $stable(bus_rdata_o)); // R9
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && !$past(wr, 2) && ($past(ext_irq_i) == $past(ext_irq_i, 2)) && ($past(ipi_i) == $past(ipi_i, 2)))
      |-> $stable(core_irq_o)); // R9

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    AST_ROUTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ok |-> ((core_irq_o[c*OUT_W+3 +: NL-1] & ~$past(route_col_flat[c*NL+1 +: NL-1])) == '0)); // R2
    AST_IPI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ok |-> ((core_irq_o[c*OUT_W +: IPI_W] & $past(ipi_i[c*IPI_W +: IPI_W])) == $past(ipi_i[c*IPI_W +: IPI_W]))); // R10
  end

endmodule

bind irq_distrib irq_distrib_chk #(
  .NUM_CORES (NUM_CORES),
  .NUM_EXT   (NUM_EXT),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ext_irq_i      (ext_irq_i),
  .ipi_i          (ipi_i),
  .bus_en_i       (bus_en_i),
  .bus_we_i       (bus_we_i),
  .bus_addr_i     (bus_addr_i),
  .bus_wdata_i    (bus_wdata_i),
  .bus_core_i     (bus_core_i),
  .bus_rdata_o    (bus_rdata_o),
  .core_irq_o     (core_irq_o),
  .en_mask        (en_mask),
  .asg_mask       (asg_mask),
  .route_col_flat (route_col_flat)
);

// File: tb/irq_distrib_tb.sv
module irq_distrib_tb;

  localparam int NC = 4;
  localparam int NE = 15;
  localparam int NL = NE + 1;
  localparam int OW = NL + 2;
  localparam int AW = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NE-1:0]     ext_irq;
  logic [NC*3-1:0]   ipi;
  logic              bus_en, bus_we;
  logic [AW-1:0]     bus_addr;
  logic [31:0]       bus_wdata;
  logic [1:0]        bus_core;
  logic [31:0]       bus_rdata;
  logic [NC*OW-1:0]  core_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [NL-1:0] m_en, m_asg;
  logic [NC-1:0] m_route [NL];
  logic [31:0]   m_rdata;

  always #4 clk = ~clk;

  irq_distrib u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_irq_i   (ext_irq),
    .ipi_i       (ipi),
    .bus_en_i    (bus_en),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_core_i  (bus_core),
    .bus_rdata_o (bus_rdata),
    .core_irq_o  (core_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] exp_out(input int c, input logic [NE-1:0] e, input logic [NC*3-1:0] p);
    logic [NL-1:0] col;
    logic [NL-1:0] act;
    for (int i = 0; i < NL; i++) col[i] = m_route[i][c];
    act = (({e, 1'b0} & m_en) | m_asg) & col;
    return {act, 2'b00} | OW'(p[c*3 +: 3]);
  endfunction

  function automatic logic [31:0] exp_read(input int a, input int core);
    if (a < NL) return 32'(m_route[a]);
    case (a)
      'h180, 'h184: return 32'(m_en);
      'h188, 'h18C: return 32'(m_asg);
      'h1A0:        return ((NC - 1) << 18) | core;
      default:      return 32'h0;
    endcase
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a < NL) m_route[a] = d[NC-1:0];
    else case (a)
      'h180: m_en  = m_en & ~d[NL-1:0];
      'h184: m_en  = m_en | d[NL-1:0];
      'h188: m_asg = m_asg & ~d[NL-1:0];
      'h18C: m_asg = m_asg | d[NL-1:0];
      default: ;
    endcase
  endtask

  task automatic step(input logic [NE-1:0] e, input logic [NC*3-1:0] p, input logic en, input logic we,
                      input int a, input logic [31:0] d, input int core, input string tag);
    @(negedge clk);
    ext_irq = e; ipi = p; bus_en = en; bus_we = we;
    bus_addr = AW'(a); bus_wdata = d; bus_core = 2'(core);
    @(posedge clk);
    #2;
    for (int c = 0; c < NC; c++) begin
      logic [OW-1:0] ex;
      ex = exp_out(c, e, p);
      check(core_irq[c*OW +: OW] == ex, {tag, " R2 out"}, 32'(core_irq[c*OW +: OW]), 32'(ex));
    end
    if (en && !we) m_rdata = exp_read(a, core);
    check(bus_rdata == m_rdata, {tag, " rdata R9"}, bus_rdata, m_rdata);
    if (en && we) model_write(a, d);
  endtask

  task automatic rd(input int a, input int core, input string tag);
    step(ext_irq, ipi, 1'b1, 1'b0, a, 32'h0, core, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    step(ext_irq, ipi, 1'b1, 1'b1, a, d, 0, tag);
  endtask

  task automatic idle(input logic [NE-1:0] e, input logic [NC*3-1:0] p, input string tag);
    step(e, p, 1'b0, 1'b0, 0, 32'h0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; ext_irq = '0; ipi = '0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_core = '0;
    m_en = '1; m_asg = '0; m_rdata = '0;
    for (int i = 0; i < NL; i++) m_route[i] = NC'(1);
    repeat (3) @(posedge clk);
    #2;
    check(core_irq == '0, "R1 outputs in reset", 32'(core_irq[31:0]), 32'h0);
    check(bus_rdata == '0, "R1 rdata in reset", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset contents
    for (int i = 0; i < NL; i++) rd(i, 0, "R1 route reset");
    rd('h184, 1, "R1 enable reset R6");
    rd('h18C, 2, "R1 assert reset R6");

    // R2: all pins high, distinct ipi per core
    idle('1, 12'hA53, "R2 all pins");
    idle('1, 12'hA53, "R9 hold");
    idle(15'h5555, 12'h0F0, "R2 pattern");

    // R3: routing with upper bits dropped
    wr(5, 32'hFFFF_FFFC, "R3 write");
    rd(5, 0, "R3 readback");
    idle(15'h0010, 12'h000, "R3 line5 to cores 2,3");
    wr(NL - 1, 32'h0000_000F, "R3 top line all cores");
    idle('1, 12'h000, "R3 top line");

    // R4: enable clear/set
    wr('h180, 32'h0000_0020, "R4 clear line5");
    idle('1, 12'h000, "R4 line5 masked");
    rd('h180, 0, "R4 R6 enable read");
    wr('h184, 32'h0000_0020, "R4 set line5");
    idle('1, 12'h000, "R4 line5 back");
    wr('h180, 32'hFFFF_FFFF, "R4 clear all");
    idle('1, 12'h000, "R4 all masked");

    // R5/R10: assert mask, line 0 collides with ipi bit 2
    wr('h18C, 32'h0000_0081, "R5 set lines 0,7");
    idle('0, 12'h000, "R10 line0 via assert");
    idle('0, 12'h444, "R10 line0 with ipi bit2");
    rd('h188, 3, "R5 R6 assert read");
    wr('h188, 32'h0000_0001, "R5 clear line0");
    idle('0, 12'h000, "R5 line7 remains");
    wr(7, 32'h0, "R5 route line7 away");
    idle('0, 12'h000, "R5 asserted but unrouted");

    // R7: configuration id for each core
    for (int c = 0; c < NC; c++) rd('h1A0, c, "R7 cfg id");

    // R8: unmapped writes ignored, reads zero
    wr('h1A0, 32'hFFFF_FFFF, "R7 cfg write ignored");
    wr('h150, 32'hFFFF_FFFF, "R8 write");
    wr('h190, 32'hFFFF_FFFF, "R8 write");
    wr(NL, 32'hFFFF_FFFF, "R8 write past lines");
    rd('h150, 0, "R8 read zero");
    rd('h1FF, 1, "R8 read zero");
    for (int i = 0; i < NL; i++) rd(i, 0, "R8 route unchanged");
    rd('h184, 0, "R8 enable unchanged");
    rd('h18C, 0, "R8 assert unchanged");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int sel, a;
      logic [31:0] d;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1, 2: a = int'($urandom_range(0, NL - 1));
        3:       a = 'h180;
        4:       a = 'h184;
        5:       a = 'h188;
        6:       a = 'h18C;
        7:       a = 'h1A0;
        default: a = int'($urandom_range(NL, 511));
      endcase
      d = $urandom();
      if (sel == 6 || sel == 5) d = d & $urandom();
      step(NE'($urandom()), (NC*3)'($urandom()), ($urandom_range(0, 3) != 0),
           $urandom_range(0, 1) == 1, a, d, int'($urandom_range(0, NC - 1)), "random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule